// File: doc/BRIEF.md
# Data-Side Local Bus Slave Responder

This block is the slave end of a processor data-cache unit's path onto a 64-bit local bus. The requester raises a request together with its attributes: direction, a 32-bit byte address, a size bit choosing one word or an eight-word line, and four storage attributes (cacheable, write-through, a user attribute and guarded). The slave acknowledges the address phase in the cycle the request first appears. In that same cycle it takes a copy of every attribute, because the requester may change them once the acknowledge has been seen.

After the acknowledge, the data phase runs from a small internal memory of 64-bit doublewords. A line read returns four beats, each tagged with its word index within the line. A line write accepts four beats. A single-word access moves one beat, and a single-word write stores only the 32-bit lane that the address picks. Busy covers the whole operation, and only one request is accepted at a time. An access that falls outside the memory or is not word-aligned still completes its data phase. It raises an error flag on its final beat.

Top module: `dside_resp`

## Requirements
- R1: When `req_valid` is high and the slave is idle, `addr_ack` is high in that same cycle, with no wait state.
- R2: `busy` is high in the acknowledge cycle and in every data beat, and falls in the cycle after the last data acknowledge. While busy, a request that is held high is not acknowledged.
- R3: The four attributes present in the acknowledge cycle appear on `held_attr` as {guarded, user, write-through, cacheable} in bits [3:0]. They stay unchanged through the data phase whatever the request inputs do. Direction, size and address are also taken from the acknowledge cycle.
- R4: A line read (`req_line`=1, `req_read`=1) produces `rd_ack` in the four cycles after the acknowledge. `rd_widx` is 0, 2, 4, 6 on those beats, and beat k carries doubleword (addr/32)*4+k.
- R5: A single-word read produces one `rd_ack` beat in the cycle after the acknowledge. `rd_widx` equals addr[4:2], and the beat carries the whole doubleword addr/8.
- R6: A line write produces `wr_ack` in the four cycles after the acknowledge. The `wr_data` of beat k is stored into doubleword (addr/32)*4+k.
- R7: A single-word write produces one `wr_ack` beat. When addr[2]=0, `wr_data[31:0]` is stored into bits [31:0] of doubleword addr/8. When addr[2]=1, `wr_data[63:32]` is stored into bits [63:32]. The other half is left unchanged.
- R8: A request whose highest doubleword index reaches DEPTH_DW, or whose addr[1:0] is non-zero, still produces its normal data acknowledges. `err` is high only on the final beat. Read data is zero and memory is not modified.
- R9: `rd_ack` and `wr_ack` are never high together, and neither is high unless `busy` is high.
- R10: During and right after reset, `addr_ack`, `busy`, `rd_ack`, `wr_ack` and `err` are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Data-access request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_line | input | 1 | 1 = eight-word line, 0 = single word |
| req_addr | input | 32 | Byte address |
| req_cacheable | input | 1 | Cacheable attribute |
| req_wthru | input | 1 | Write-through attribute |
| req_uattr | input | 1 | User-defined attribute |
| req_guarded | input | 1 | Guarded attribute |
| wr_data | input | 64 | Write-data bus |
| addr_ack | output | 1 | Address-phase acknowledge |
| busy | output | 1 | Operation in progress |
| rd_ack | output | 1 | Read-data valid strobe |
| rd_data | output | 64 | Read-data bus |
| rd_widx | output | 3 | Word index of the current read beat |
| wr_ack | output | 1 | Write-data accepted strobe |
| err | output | 1 | Transfer fault, on the final beat |
| held_attr | output | 4 | Attributes captured at acknowledge |

## Verification
The assertions check four behaviours on every cycle: that the captured request equals the inputs of the acknowledge cycle, that the held attributes stay stable while busy, that strobes appear only under busy and never together, and that an error appears only on a final beat. Only the bench scenarios can show three further properties. The first is that data actually lands in the right doubleword and lane. The second is that the beat indices and read data follow the line base. The third is that out-of-range or misaligned accesses leave memory untouched, which the bench shows by reading it back through the bus afterwards.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 64;
  localparam int LINE_BEATS = 4;
  localparam int BEAT_W     = $clog2(LINE_BEATS);
  localparam int WIDX_W     = 3;

  typedef struct packed {
    logic guarded;
    logic uattr;
    logic wthru;
    logic cacheable;
  } attr_t;

  typedef struct packed {
    logic              is_read;
    logic              line;
    logic [ADDR_W-1:0] addr;
    attr_t             attr;
  } req_t;

  // doubleword number touched by a given beat
  function automatic logic [31:0] dw_of(input logic line,
                                        input logic [31:0] addr,
                                        input logic [1:0] beat);
    return line ? {3'b000, addr[31:5], beat} : {3'b000, addr[31:3]};
  endfunction

  // word index within the eight-word line reported with a read beat
  function automatic logic [2:0] widx_of(input logic line,
                                         input logic [31:0] addr,
                                         input logic [1:0] beat);
    return line ? {beat, 1'b0} : addr[4:2];
  endfunction

  // which 32-bit halves a beat writes: bit0 = low half, bit1 = high half
  function automatic logic [1:0] half_mask(input logic line, input logic [31:0] addr);
    return line ? 2'b11 : (addr[2] ? 2'b10 : 2'b01);
  endfunction

endpackage

// File: rtl/dsr_addr_phase.sv
module dsr_addr_phase
  import dsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  req_t req_in,
  input  logic busy_q,
  output logic addr_ack,
  output req_t req_q
);

  // zero-wait acknowledge: combinational from request and idle state
  assign addr_ack = req_valid & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (addr_ack) begin
      req_q <= req_in;
    end
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> (req_q == $past(req_in)));

endmodule

// File: rtl/dsr_beat_seq.sv
module dsr_beat_seq
  import dsr_pkg::*;
#(
  parameter int DEPTH_DW = 32,
  parameter int IDX_W    = $clog2(DEPTH_DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ack,
  input  logic              is_read,
  input  logic              line,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy_q,
  output logic              beat_last,
  output logic              beat_ok,
  output logic              rd_ack,
  output logic              wr_ack,
  output logic              err,
  output logic [WIDX_W-1:0] rd_widx,
  output logic [IDX_W-1:0]  dw_idx,
  output logic              wr_en,
  output logic [1:0]        wr_mask
);

  logic [BEAT_W-1:0] beat_q;
  logic [31:0]       dw_full;
  logic              aligned;

  assign beat_last = !line || (beat_q == BEAT_W'(LINE_BEATS - 1));
  assign dw_full   = dw_of(line, addr, beat_q);
  assign aligned   = (addr[1:0] == 2'b00);
  // memory depth is a multiple of a line, so a line is wholly in or out
  assign beat_ok   = aligned && (dw_full < 32'(DEPTH_DW));
  assign dw_idx    = dw_full[IDX_W-1:0];

  assign rd_ack  = busy_q & is_read;
  assign wr_ack  = busy_q & ~is_read;
  assign err     = busy_q & beat_last & ~beat_ok;
  assign rd_widx = rd_ack ? widx_of(line, addr, beat_q) : '0;
  assign wr_en   = wr_ack & beat_ok;
  assign wr_mask = half_mask(line, addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (addr_ack) begin
      busy_q <= 1'b1;
      beat_q <= '0;
    end else if (busy_q) begin
      if (beat_last) busy_q <= 1'b0;
      else           beat_q <= beat_q + 1'b1;
    end
  end

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !beat_last) |=> busy_q);

  // R8
  err_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (beat_last && (rd_ack || wr_ack)));

endmodule

// File: rtl/dsr_store.sv
module dsr_store
  import dsr_pkg::*;
#(
  parameter int DEPTH_DW = 32,
  parameter int IDX_W    = $clog2(DEPTH_DW)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_mask,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int HALF_W = DATA_W / 2;

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [HALF_W-1:0] cells [DEPTH_DW];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) cells[idx] <= wdata[g*HALF_W +: HALF_W];
    end

    assign rdata[g*HALF_W +: HALF_W] = cells[idx];
  end

endmodule

// File: rtl/dside_resp.sv
module dside_resp
  import dsr_pkg::*;
#(
  parameter int DEPTH_DW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic        req_line,
  input  logic [31:0] req_addr,
  input  logic        req_cacheable,
  input  logic        req_wthru,
  input  logic        req_uattr,
  input  logic        req_guarded,
  input  logic [63:0] wr_data,
  output logic        addr_ack,
  output logic        busy,
  output logic        rd_ack,
  output logic [63:0] rd_data,
  output logic [2:0]  rd_widx,
  output logic        wr_ack,
  output logic        err,
  output logic [3:0]  held_attr
);

  localparam int IDX_W = $clog2(DEPTH_DW);

  req_t              req_in;
  req_t              req_q;
  logic              busy_q;
  logic              beat_last;
  logic              beat_ok;
  logic [IDX_W-1:0]  dw_idx;
  logic              wr_en;
  logic [1:0]        wr_mask;
  logic [DATA_W-1:0] mem_rdata;

  always_comb begin
    req_in                = '0;
    req_in.is_read        = req_read;
    req_in.line           = req_line;
    req_in.addr           = req_addr;
    req_in.attr.cacheable = req_cacheable;
    req_in.attr.wthru     = req_wthru;
    req_in.attr.uattr     = req_uattr;
    req_in.attr.guarded   = req_guarded;
  end

  dsr_addr_phase u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_in   (req_in),
    .busy_q   (busy_q),
    .addr_ack (addr_ack),
    .req_q    (req_q)
  );

  dsr_beat_seq #(.DEPTH_DW(DEPTH_DW), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_ack (addr_ack),
    .is_read  (req_q.is_read),
    .line     (req_q.line),
    .addr     (req_q.addr),
    .busy_q   (busy_q),
    .beat_last(beat_last),
    .beat_ok  (beat_ok),
    .rd_ack   (rd_ack),
    .wr_ack   (wr_ack),
    .err      (err),
    .rd_widx  (rd_widx),
    .dw_idx   (dw_idx),
    .wr_en    (wr_en),
    .wr_mask  (wr_mask)
  );

  dsr_store #(.DEPTH_DW(DEPTH_DW), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_mask(wr_mask),
    .idx    (dw_idx),
    .wdata  (wr_data),
    .rdata  (mem_rdata)
  );

  assign busy      = busy_q | addr_ack;
  assign rd_data   = (rd_ack && beat_ok) ? mem_rdata : '0;
  assign held_attr = req_q.attr;

  // R3
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(held_attr));

  // R4
  line_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && req_q.line) |-> !rd_widx[0]);

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack || wr_ack) |-> (busy && !(rd_ack && wr_ack)));

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(rd_ack || wr_ack));

endmodule

// File: tb/dside_resp_tb.sv
module dside_resp_tb;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic        req_line = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_cacheable = 1'b0;
  logic        req_wthru = 1'b0;
  logic        req_uattr = 1'b0;
  logic        req_guarded = 1'b0;
  logic [63:0] wr_data = '0;
  logic        addr_ack, busy, rd_ack, wr_ack, err;
  logic [63:0] rd_data;
  logic [2:0]  rd_widx;
  logic [3:0]  held_attr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] model [DEPTH];

  always #2 clk = ~clk;

  dside_resp #(.DEPTH_DW(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_line(req_line), .req_addr(req_addr), .req_cacheable(req_cacheable),
    .req_wthru(req_wthru), .req_uattr(req_uattr), .req_guarded(req_guarded),
    .wr_data(wr_data), .addr_ack(addr_ack), .busy(busy), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_widx(rd_widx), .wr_ack(wr_ack), .err(err),
    .held_attr(held_attr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one complete transfer; hold_req keeps a second request pending while busy
  task automatic xfer(input logic rd, input logic ln, input logic [31:0] a,
                      input logic [3:0] at, input logic [63:0] wbase,
                      input logic hold_req);
    int n;
    int lastdw;
    logic ok;
    @(negedge clk);
    req_read = rd; req_line = ln; req_addr = a;
    {req_guarded, req_uattr, req_wthru, req_cacheable} = at;
    req_valid = 1'b1;
    #1;
    chk("R1 addr_ack", addr_ack, 1);
    chk("R2 busy at ack", busy, 1);
    n      = ln ? 4 : 1;
    lastdw = ln ? int'(a >> 5) * 4 + 3 : int'(a >> 3);
    ok     = (a[1:0] == 2'b00) && (lastdw < DEPTH);
    for (int b = 0; b < n; b++) begin
      int dw;
      logic [63:0] wd;
      @(negedge clk);
      if (b == 0) begin
        req_valid = hold_req;
        req_addr = ~a; req_read = ~rd; req_line = ~ln;
        {req_guarded, req_uattr, req_wthru, req_cacheable} = ~at;
      end
      wd = wbase + 64'(b);
      wr_data = wd;
      #1;
      dw = ln ? int'(a >> 5) * 4 + b : int'(a >> 3);
      chk("R2 busy in beat", busy, 1);
      chk("R3 held_attr", held_attr, at);
      chk("R9 rd_ack", rd_ack, rd);
      chk("R9 wr_ack", wr_ack, !rd);
      chk("R8 err", err, (!ok && b == n - 1));
      if (hold_req) chk("R2 no ack while busy", addr_ack, 0);
      if (rd) begin
        chk(ln ? "R4 widx" : "R5 widx", rd_widx, ln ? 3'(2 * b) : a[4:2]);
        chk(ln ? "R4 data" : (ok ? "R5 data" : "R8 data"), rd_data, ok ? model[dw] : 64'h0);
      end else if (ok) begin
        if (ln) model[dw] = wd;
        else if (a[2]) model[dw][63:32] = wd[63:32];
        else model[dw][31:0] = wd[31:0];
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R2 busy falls", busy, 0);
    chk("R9 no strobe idle", rd_ack | wr_ack, 0);
  endtask

  task automatic read_all_lines();
    for (int l = 0; l < DEPTH / 4; l++) xfer(1'b1, 1'b1, 32'(l * 32), 4'(l), '0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R10 addr_ack", addr_ack, 0);
    chk("R10 busy", busy, 0);
    chk("R10 strobes", {rd_ack, wr_ack, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 after reset", {addr_ack, busy, rd_ack, wr_ack, err}, 0);

    // R6 line writes over every line, attributes swept
    for (int l = 0; l < DEPTH / 4; l++)
      xfer(1'b0, 1'b1, 32'(l * 32), 4'(15 - l), {32'hC0DE0000 + 32'(l), 32'(l) << 8}, 1'b0);
    // R4 line reads back
    read_all_lines();
    // R5 word reads, every word, R3 all attribute codes
    for (int w = 0; w < DEPTH * 2; w++) xfer(1'b1, 1'b0, 32'(w * 4), 4'(w), '0, 1'b0);
    // R7 word writes, both lanes carry different data
    for (int w = 0; w < DEPTH * 2; w += 3)
      xfer(1'b0, 1'b0, 32'(w * 4), 4'(w), {32'h5A000000 + 32'(w), 32'hA5000000 + 32'(w)}, 1'b0);
    read_all_lines();
    // R2 request held high through the data phase
    xfer(1'b1, 1'b1, 32'h40, 4'hA, '0, 1'b1);
    xfer(1'b0, 1'b0, 32'h14, 4'h5, 64'h1111_2222_3333_4444, 1'b1);
    xfer(1'b1, 1'b0, 32'h14, 4'h3, '0, 1'b0);
    // R8 out of range and misaligned accesses, memory untouched
    xfer(1'b1, 1'b1, 32'(DEPTH * 8), 4'h1, '0, 1'b0);
    xfer(1'b0, 1'b1, 32'(DEPTH * 8 + 32), 4'h2, 64'hDEAD_BEEF_0000_0000, 1'b0);
    xfer(1'b0, 1'b0, 32'(DEPTH * 8), 4'h3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    xfer(1'b1, 1'b0, 32'h0A, 4'h4, '0, 1'b0);
    xfer(1'b0, 1'b0, 32'h0D, 4'h6, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    xfer(1'b0, 1'b1, 32'h21, 4'h7, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    xfer(1'b1, 1'b0, 32'(DEPTH * 8 - 8), 4'h8, '0, 1'b0);
    read_all_lines();
    finish_run();
  end

endmodule